// File: doc/BRIEF.md
# Atomic Memory Operation Controller

This block sits between one core's load/store port and a word-addressed memory with a one-cycle read latency. It runs three kinds of request: load-reserved, store-conditional, and read-modify-write atomics. An atomic reads a word, combines it with the request's source operand, writes the result back to the same word, and returns the word's old value. A reservation register holds the word address that the last load-reserved captured. A snoop input reports writes made by other agents, and a matching snoop clears the reservation.

The controller drives a lock output to the memory for the whole locked read/write pair. No other requester can slip an access in between the read and the write. Addresses must be word aligned. A misaligned request, or one with an unknown operation code, gets a fault response and never reaches memory. Each request also carries an acquire bit and a release bit. Release holds the memory access back until an external drain input reports that earlier accesses have completed. Acquire keeps the controller from taking the next request in the same cycle as the response. Both bits are also presented on outputs while their request is in progress.

Top module: `amo_unit`

## Requirements
- R1: Load-reserved (operation code 0) returns the addressed word and records that word address as the reservation; it writes nothing.
- R2: Store-conditional (code 1) writes its source operand and returns 0 only while a reservation exists for the same word; otherwise it returns 1 and leaves memory unchanged. Every store-conditional clears the reservation, whether it succeeds or fails.
- R3: A snoop write whose word address equals the reserved word clears the reservation, and this includes a snoop in the cycle a store-conditional is evaluated. A snoop to any other word leaves the reservation in place.
- R4: Atomic codes 2 swap, 3 add, 4 AND, 5 OR, 6 XOR each return the old word and write back the combination of the old word with the source operand (swap writes the source). Without release, the response is presented in the third cycle after acceptance.
- R5: Codes 7 and 8 write back the signed minimum and signed maximum. Codes 9 and 10 write back the unsigned minimum and unsigned maximum. All four return the old word.
- R6: For an atomic, the lock output is high in the read cycle and in the write cycle, and the write follows the read in the very next cycle at the same address.
- R7: A request whose byte address has a nonzero value in bits [1:0], or whose code is above 10, gets a response with the fault bit set and data 0. It performs no memory access.
- R8: With the release bit set, no memory access is issued until the drain input is high.
- R9: A request with the acquire bit holds the ready output low during its response cycle. Without the bit, ready is high in that cycle.
- R10: After reset, ready is high, no response is presented, lock is low and no reservation exists.
- R11: The acquire and release outputs show the bits of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Byte address |
| req_data | input | XLEN | Source operand |
| req_aq | input | 1 | Acquire bit |
| req_rl | input | 1 | Release bit |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | XLEN | Value for the destination register |
| rsp_fault | output | 1 | Alignment or code fault |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, one cycle after the read |
| mem_lock | output | 1 | Memory locked against other requesters |
| snoop_valid | input | 1 | Another agent writes memory |
| snoop_addr | input | AW-2 | Word written by the other agent |
| drain_done | input | 1 | Earlier accesses have completed |
| ord_aq | output | 1 | Acquire bit of the request in progress |
| ord_rl | output | 1 | Release bit of the request in progress |

## Verification
The hardest states to reach are the ones where the reservation is gone but memory looks the same: a store-conditional after a failed one, one aimed at a different word, and one that follows a snoop. The bench reaches each of these by sequencing load-reserved, snoop pulses and store-conditionals in a fixed order. It then reads the word back with a fresh load-reserved to show whether memory changed. A release request is held with the drain input low for several cycles while the bench watches that the memory strobe stays quiet.

// File: rtl/amo_pkg.sv
// Shared operation codes and sequencer states for the atomic controller.
// Assumes a 4-bit operation field; codes above OP_MAXU are illegal.
package amo_pkg;
    typedef enum logic [3:0] {
        OP_LR   = 4'd0,
        OP_SC   = 4'd1,
        OP_SWAP = 4'd2,
        OP_ADD  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAXU = 4'd10
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_READ,
        ST_MODIFY,
        ST_COND,
        ST_RESP
    } amo_state_e;

    localparam logic [3:0] OP_LAST = 4'd10;
endpackage

// File: rtl/amo_alu.sv
// Combines the word read from memory with the source operand.
// Assumes op is a read-modify-write code; other codes return the source.
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    output logic [XLEN-1:0] new_val
);
    logic s_less;
    logic u_less;

    // Signed and unsigned comparison of old word against source.
    always_comb begin
        s_less = $signed(old_val) < $signed(src_val);
        u_less = old_val < src_val;
    end

    // Select the value written back.
    always_comb begin
        case (op)
            OP_ADD:  new_val = old_val + src_val;
            OP_AND:  new_val = old_val & src_val;
            OP_OR:   new_val = old_val | src_val;
            OP_XOR:  new_val = old_val ^ src_val;
            OP_MIN:  new_val = s_less ? old_val : src_val;
            OP_MAX:  new_val = s_less ? src_val : old_val;
            OP_MINU: new_val = u_less ? old_val : src_val;
            OP_MAXU: new_val = u_less ? src_val : old_val;
            default: new_val = src_val;
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
// Reservation tracker: holds one word address set by load-reserved.
// Assumes set has priority over clear in the same cycle.
module amo_resv #(
    parameter int WA = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [WA-1:0] set_addr,
    input  logic          clr_en,
    input  logic          snoop_valid,
    input  logic [WA-1:0] snoop_addr,
    input  logic [WA-1:0] chk_addr,
    output logic          hit
);
    logic          valid_q;
    logic [WA-1:0] addr_q;
    logic          snoop_match;

    // A foreign write to the reserved word breaks the reservation.
    always_comb snoop_match = snoop_valid && (snoop_addr == addr_q);

    // Reservation still held for the checked word this cycle.
    always_comb hit = valid_q && (addr_q == chk_addr) && !snoop_match;

    // Update the reservation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr;
        end else if (clr_en || snoop_match) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/amo_unit.sv
// Atomic memory operation controller: sequences load-reserved,
// store-conditional and locked read-modify-write operations.
// Assumes memory returns read data one cycle after mem_en with !mem_we.
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [3:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [XLEN-1:0] req_data,
    input  logic            req_aq,
    input  logic            req_rl,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_data,
    output logic            rsp_fault,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-3:0]   mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_lock,
    input  logic            snoop_valid,
    input  logic [AW-3:0]   snoop_addr,
    input  logic            drain_done,
    output logic            ord_aq,
    output logic            ord_rl
);
    localparam int WA = AW - 2;

    amo_state_e      state_q, state_d;
    logic [3:0]      op_q;
    logic [WA-1:0]   waddr_q;
    logic [XLEN-1:0] src_q;
    logic            aq_q, rl_q;
    logic [XLEN-1:0] data_q;
    logic            fault_q;
    logic            accept, bad_req, resv_hit;
    logic [XLEN-1:0] alu_out;
    amo_state_e      launch;

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .old_val (mem_rdata),
        .src_val (src_q),
        .new_val (alu_out)
    );

    amo_resv #(.WA(WA)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (state_q == ST_MODIFY && op_q == OP_LR),
        .set_addr    (waddr_q),
        .clr_en      (state_q == ST_COND),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .chk_addr    (waddr_q),
        .hit         (resv_hit)
    );

    // Handshake: idle, or a response cycle whose request lacks acquire.
    always_comb begin
        req_ready = (state_q == ST_IDLE) || (state_q == ST_RESP && !aq_q);
        accept    = req_valid && req_ready;
        bad_req   = (req_addr[1:0] != 2'b00) || (req_op > OP_LAST);
    end

    // First state of a freshly accepted request.
    always_comb begin
        if (bad_req)                  launch = ST_RESP;
        else if (req_rl && !drain_done) launch = ST_DRAIN;
        else if (req_op == OP_SC)     launch = ST_COND;
        else                          launch = ST_READ;
    end

    // Sequencer next-state logic.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = launch;
            ST_DRAIN:  if (drain_done) state_d = (op_q == OP_SC) ? ST_COND : ST_READ;
            ST_READ:   state_d = ST_MODIFY;
            ST_MODIFY: state_d = ST_RESP;
            ST_COND:   state_d = ST_RESP;
            ST_RESP:   state_d = accept ? launch : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            waddr_q <= '0;
            src_q   <= '0;
            aq_q    <= 1'b0;
            rl_q    <= 1'b0;
        end else if (accept) begin
            op_q    <= req_op;
            waddr_q <= req_addr[AW-1:2];
            src_q   <= req_data;
            aq_q    <= req_aq;
            rl_q    <= req_rl;
        end
    end

    // Capture the response value and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            fault_q <= 1'b0;
        end else if (accept && bad_req) begin
            data_q  <= '0;
            fault_q <= 1'b1;
        end else if (state_q == ST_MODIFY) begin
            data_q  <= mem_rdata;
            fault_q <= 1'b0;
        end else if (state_q == ST_COND) begin
            data_q  <= resv_hit ? '0 : XLEN'(1);
            fault_q <= 1'b0;
        end
    end

    // Memory port drive for each sequencer state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = waddr_q;
        mem_wdata = src_q;
        case (state_q)
            ST_READ:   mem_en = 1'b1;
            ST_MODIFY: begin
                mem_en    = (op_q != OP_LR);
                mem_we    = (op_q != OP_LR);
                mem_wdata = alu_out;
            end
            ST_COND: begin
                mem_en = resv_hit;
                mem_we = resv_hit;
            end
            default: ;
        endcase
        mem_lock = (state_q == ST_READ || state_q == ST_MODIFY) && (op_q != OP_LR);
    end

    // Response and ordering outputs.
    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_data  = data_q;
        rsp_fault = fault_q;
        ord_aq    = (state_q != ST_IDLE) && aq_q;
        ord_rl    = (state_q != ST_IDLE) && rl_q;
    end
endmodule

// File: rtl/amo_unit_chk.sv
// Protocol checker for amo_unit, attached through bind.
// Assumes the same clock and synchronous active-low reset as the unit.
module amo_unit_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_data,
    input logic            rsp_fault,
    input logic            mem_en,
    input logic            mem_we,
    input logic            mem_lock,
    input logic            drain_done,
    input logic            ord_aq,
    input logic            ord_rl
);
    assert_lock_spans_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && mem_lock) |=> (mem_en && mem_we && mem_lock));

    assert_locked_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_we) |-> $past(mem_lock && mem_en && !mem_we));

    assert_write_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_fault_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($past(!mem_en) && rsp_data == '0));

    assert_drain_before_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && ord_rl) |-> $past(drain_done));

    assert_acquire_blocks_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ord_aq) |-> !req_ready);
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_fault  (rsp_fault),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .drain_done (drain_done),
    .ord_aq     (ord_aq),
    .ord_rl     (ord_rl)
);

// File: tb/sim_amo_unit.sv
// Bench for amo_unit: a vector table walked in order, then directed tests.
module sim_amo_unit;
    localparam int XLEN = 32;
    localparam int AW   = 8;
    localparam int WA   = AW - 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [3:0]      req_op = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [XLEN-1:0] req_data = '0;
    logic            req_aq = 1'b0;
    logic            req_rl = 1'b0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_data;
    logic            rsp_fault;
    logic            mem_en, mem_we, mem_lock;
    logic [WA-1:0]   mem_addr;
    logic [XLEN-1:0] mem_wdata;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            snoop_valid = 1'b0;
    logic [WA-1:0]   snoop_addr = '0;
    logic            drain_done = 1'b1;
    logic            ord_aq, ord_rl;

    logic [XLEN-1:0] mem [2**WA];
    int checks = 0;
    int fails  = 0;
    int lock_cnt = 0;
    int en_cnt = 0;

    always #10 clk = ~clk;

    amo_unit #(.XLEN(XLEN), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_aq(req_aq), .req_rl(req_rl),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_lock(mem_lock),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .drain_done(drain_done),
        .ord_aq(ord_aq), .ord_rl(ord_rl)
    );

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    end

    // Monitor counts lock and strobe cycles between samples.
    always @(negedge clk) begin
        if (mem_lock) lock_cnt <= lock_cnt + 1;
        if (mem_en) en_cnt <= en_cnt + 1;
    end

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        aq;
        logic        rl;
        logic [31:0] exp;
        logic        fault;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'd3,  8'h04, 32'h5,        1'b0, 1'b0, 32'h10,       1'b0}, // R4 add
        '{4'd0,  8'h04, 32'h0,        1'b0, 1'b0, 32'h15,       1'b0}, // R1 lr
        '{4'd1,  8'h04, 32'hAA,       1'b0, 1'b0, 32'h0,        1'b0}, // R2 sc ok
        '{4'd1,  8'h04, 32'hBB,       1'b0, 1'b0, 32'h1,        1'b0}, // R2 sc again fails
        '{4'd0,  8'h04, 32'h0,        1'b0, 1'b0, 32'hAA,       1'b0}, // R2 memory kept
        '{4'd2,  8'h08, 32'hFFFFFFF0, 1'b1, 1'b0, 32'h20,       1'b0}, // R4 swap, aq
        '{4'd7,  8'h08, 32'h5,        1'b0, 1'b0, 32'hFFFFFFF0, 1'b0}, // R5 min signed
        '{4'd9,  8'h08, 32'h5,        1'b0, 1'b0, 32'hFFFFFFF0, 1'b0}, // R5 minu
        '{4'd8,  8'h08, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h5,        1'b0}, // R5 max signed
        '{4'd10, 8'h08, 32'h80000000, 1'b0, 1'b0, 32'h5,        1'b0}, // R5 maxu
        '{4'd4,  8'h0C, 32'h1F,       1'b0, 1'b1, 32'h30,       1'b0}, // R4 and, rl
        '{4'd5,  8'h0C, 32'h03,       1'b0, 1'b0, 32'h10,       1'b0}, // R4 or
        '{4'd6,  8'h0C, 32'h11,       1'b0, 1'b0, 32'h13,       1'b0}, // R4 xor
        '{4'd0,  8'h0C, 32'h0,        1'b0, 1'b0, 32'h02,       1'b0}, // R1 lr
        '{4'd1,  8'h04, 32'h77,       1'b0, 1'b0, 32'h1,        1'b0}, // R2 other word fails
        '{4'd1,  8'h0C, 32'h99,       1'b0, 1'b0, 32'h1,        1'b0}, // R2 cleared by fail
        '{4'd3,  8'h09, 32'h1,        1'b0, 1'b0, 32'h0,        1'b1}, // R7 misaligned
        '{4'd15, 8'h08, 32'h1,        1'b0, 1'b0, 32'h0,        1'b1}, // R7 unknown code
        '{4'd0,  8'h08, 32'h0,        1'b0, 1'b0, 32'h80000000, 1'b0}, // R7 word untouched
        '{4'd8,  8'h0C, 32'h50,       1'b0, 1'b0, 32'h02,       1'b0}, // R5 max
        '{4'd0,  8'h0C, 32'h0,        1'b0, 1'b0, 32'h50,       1'b0}, // R5 result
        '{4'd0,  8'h04, 32'h0,        1'b0, 1'b0, 32'hAA,       1'b0}  // R2 no write
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for its response; reports ready in that cycle.
    task automatic run_req(input logic [3:0] op, input logic [7:0] a, input logic [31:0] d,
                           input logic aq, input logic rl,
                           output logic [31:0] rd, output logic rf, output logic rdy);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_aq = aq; req_rl = rl;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_aq = 1'b0; req_rl = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_data; rf = rsp_fault; rdy = req_ready;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic rf, rdy;
        for (int i = 0; i < 2**WA; i++) mem[i] = 32'(i) * 32'h10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 ready", {31'b0, req_ready}, 32'h1);
        chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R10 lock", {31'b0, mem_lock}, 32'h0);
        rst_n = 1'b1;
        // R10: no reservation after reset
        run_req(4'd1, 8'h18, 32'h1234, 1'b0, 1'b0, rd, rf, rdy);
        chk("R10 sc after reset", rd, 32'h1);
        run_req(4'd0, 8'h18, 32'h0, 1'b0, 1'b0, rd, rf, rdy);
        chk("R10 word kept", rd, 32'h60);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            run_req(TBL[k].op, TBL[k].addr, TBL[k].data, TBL[k].aq, TBL[k].rl, rd, rf, rdy);
            chk($sformatf("R1-R7 vec%0d data", k), rd, TBL[k].exp);
            chk($sformatf("R7 vec%0d fault", k), {31'b0, rf}, {31'b0, TBL[k].fault});
        end

        // R3: snoop to another word keeps reservation
        run_req(4'd0, 8'h10, 32'h0, 1'b0, 1'b0, rd, rf, rdy);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = 6'd5;
        @(negedge clk); snoop_valid = 1'b0;
        run_req(4'd1, 8'h10, 32'h123, 1'b0, 1'b0, rd, rf, rdy);
        chk("R3 other snoop sc", rd, 32'h0);
        // R3: matching snoop clears reservation
        run_req(4'd0, 8'h10, 32'h0, 1'b0, 1'b0, rd, rf, rdy);
        chk("R3 lr value", rd, 32'h123);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = 6'd4;
        @(negedge clk); snoop_valid = 1'b0;
        run_req(4'd1, 8'h10, 32'h456, 1'b0, 1'b0, rd, rf, rdy);
        chk("R3 matching snoop sc", rd, 32'h1);
        run_req(4'd0, 8'h10, 32'h0, 1'b0, 1'b0, rd, rf, rdy);
        chk("R3 word kept", rd, 32'h123);

        // R9: ready in response cycle with and without acquire
        run_req(4'd3, 8'h14, 32'h1, 1'b1, 1'b0, rd, rf, rdy);
        chk("R9 aq ready low", {31'b0, rdy}, 32'h0);
        run_req(4'd3, 8'h14, 32'h1, 1'b0, 1'b0, rd, rf, rdy);
        chk("R9 no aq ready high", {31'b0, rdy}, 32'h1);
        chk("R4 add chain", rd, 32'h51);

        // R6: lock held for exactly read and write cycles
        @(negedge clk); lock_cnt = 0;
        run_req(4'd2, 8'h1C, 32'hABC, 1'b0, 1'b0, rd, rf, rdy);
        chk("R6 lock cycles", 32'(lock_cnt), 32'd2);
        chk("R6 swap old", rd, 32'h70);

        // R8/R11: release waits for drain
        drain_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd3; req_addr = 8'h20; req_data = 32'h2; req_rl = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_rl = 1'b0;
        en_cnt = 0;
        repeat (5) @(negedge clk);
        chk("R8 no access before drain", 32'(en_cnt), 32'd0);
        chk("R11 release shown", {31'b0, ord_rl}, 32'h1);
        chk("R11 acquire clear", {31'b0, ord_aq}, 32'h0);
        drain_done = 1'b1;
        while (!rsp_valid) @(negedge clk);
        chk("R8 add after drain", rsp_data, 32'h80);
        run_req(4'd0, 8'h20, 32'h0, 1'b0, 1'b0, rd, rf, rdy);
        chk("R8 written", rd, 32'h82);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule